// File: doc/BRIEF.md
# Bus Master Termination and Retry Controller

This block runs the bus-side life of one transaction that a bridge launches as a bus master. A request is accepted on a valid/ready handshake. The block then drives an address phase and opens a device-select window. It steps through the data phases that the bus interface reports and decides how the tenure ends. The possible endings are normal completion, an initiator disconnect at an allowable disconnect boundary, a master abort, a target abort, a target disconnect followed by re-launch, or a target retry followed by a spaced reissue.

It tracks the next address and the beats that remain. A beat is 8 bytes. Allowable disconnect boundaries lie on 128-byte aligned addresses. A re-launched tenure carries only the leftover length. When the transaction is finished, the block presents a status code and the number of beats moved on a completion valid/ready port. The completion holds steady while `cpl_ready` is low, and no new request is taken until it is consumed. Two sticky flags record received master aborts and received target aborts. Each flag clears only by a write-one pulse on its own clear bit.

Request back-pressure is simple: `req_ready` is high only when the block is idle, and a request is taken on any cycle where `req_valid` and `req_ready` are both high. Status flag encoding: bit 0 is master abort received, bit 1 is target abort received. Completion status encoding: 00 normal, 01 master abort, 10 target abort.

Top module: `mt_term_ctrl`

## Requirements
- R1: A request taken on `req_valid && req_ready` produces `addr_phase` in the next cycle. In that cycle `bus_addr` and `bus_beats` equal the request's address and beat count. At most one of `req_ready`, `addr_phase`, `dphase` and `cpl_valid` is high in any cycle.
- R2: If `dev_sel` is sampled high in any of the 1st to 6th cycles after the address phase, data phases follow. If it is not seen by the 6th cycle, the transaction completes with status 01, carries the beats moved so far, and sets flag bit 0.
- R3: A special-cycle request that sees no `dev_sel` within the window completes with status 00 and one beat counted, and leaves flag bit 0 untouched. A special-cycle request that does get `dev_sel` ends after its first data phase.
- R4: When the last remaining beat is accepted, the transaction completes with status 00 and `cpl_beats` equal to the requested count.
- R5: A write is never ended early by an initiator disconnect, whatever the buffer, latency timer or grant state.
- R6: A split-completion read whose buffer is empty (`buf_empty` high) when an accepted beat lands the next address on a 128-byte boundary is disconnected. `init_disc` pulses in the next cycle. The re-launch waits while the buffer stays empty.
- R7: A read is disconnected at such a boundary when `lat_expired` is high and `gnt` is low, and re-launches only once `gnt` returns. With `gnt` high, no disconnect occurs.
- R8: A data phase accepted together with `tgt_disc` that is not the last beat causes a new address phase in the next cycle. That address phase carries the advanced address and the remaining beats.
- R9: After a retry response, exactly two idle cycles pass and the address phase is reissued in the third cycle. Retries repeat until the transaction ends.
- R10: A target abort on any data phase completes with status 10, reports the beats accepted before it, and sets flag bit 1.
- R11: Each sticky flag stays set until a pulse on its own `sts_clr` bit. A pulse on one bit does not clear the other flag, and a set in the same cycle wins over the clear.
- R12: `cpl_valid`, `cpl_status` and `cpl_beats` hold while `cpl_ready` is low. The block returns to idle in the cycle after the completion is taken.
- R13: After reset, `req_ready` is high and `addr_phase`, `dphase`, `cpl_valid`, `init_disc` and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New transaction offered |
| req_ready | output | 1 | Block idle, able to take a request |
| req_write | input | 1 | Transaction is a write |
| req_split | input | 1 | Transaction is a split-completion read |
| req_special | input | 1 | Configuration request translated into a special cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_beats | input | CNT_W | Length in 8-byte beats (at least 1) |
| addr_phase | output | 1 | Address phase this cycle |
| bus_addr | output | ADDR_W | Next address to transfer |
| bus_beats | output | CNT_W | Beats still to transfer |
| dphase | output | 1 | Data phases in progress |
| dev_sel | input | 1 | Target claimed the transaction |
| data_ack | input | 1 | One beat accepted this cycle |
| tgt_disc | input | 1 | Target disconnects after this beat |
| tgt_retry | input | 1 | Target signals retry |
| tgt_abort | input | 1 | Target signals abort |
| buf_empty | input | 1 | Outgoing data buffer has run dry |
| lat_expired | input | 1 | Master latency timer has run out |
| gnt | input | 1 | Bus grant held |
| init_disc | output | 1 | Pulse: an initiator disconnect just occurred |
| cpl_valid | output | 1 | Completion result available |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_status | output | 2 | 00 normal, 01 master abort, 10 target abort |
| cpl_beats | output | CNT_W | Beats moved over the whole transaction |
| sts_clr | input | 2 | Write-one clear for the sticky flags |
| sts_flags | output | 2 | Sticky flags: bit 0 master abort, bit 1 target abort |

## Verification
Results have fixed latencies. The address phase appears one cycle after the request is taken. The completion and both sticky flags appear one cycle after the clock edge that samples the deciding response. `init_disc` appears one cycle after the boundary beat, and a re-launch appears one cycle after the release of the buffer or grant, or three cycles after a retry. The bench acts as a reactive target. On every falling edge it first samples the outputs and then drives the responses for the next rising edge. Each observation is therefore tied to the exact cycle in which the design must have acted. The bench sweeps device-select delays across the window edge, retry counts, disconnect positions and start offsets relative to the 128-byte boundary, and checks the captured results against counts computed from those offsets.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_DATA,
    ST_GAP,
    ST_HOLD,
    ST_DONE
  } mt_state_e;

  typedef enum logic [1:0] {
    CPL_OK     = 2'b00,
    CPL_MABORT = 2'b01,
    CPL_TABORT = 2'b10
  } mt_cpl_e;

endpackage

// File: rtl/mt_devsel_window.sv
module mt_devsel_window #(
  parameter int WINDOW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic waiting,
  input  logic dev_sel,
  output logic timeout
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CW'(1);
    else if (waiting && !dev_sel && cnt != CW'(WINDOW))
      cnt <= cnt + CW'(1);
  end

  assign timeout = waiting && !dev_sel && (cnt == CW'(WINDOW));
endmodule

// File: rtl/mt_xfer_track.sv
module mt_xfer_track #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int BEAT_BYTES = 8,
  parameter int ADB_BYTES  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_beats,
  input  logic              step,
  input  logic              bump,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  rem,
  output logic [CNT_W-1:0]  moved,
  output logic              last,
  output logic              adb_next
);
  localparam int ADB_LSB = $clog2(ADB_BYTES);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] nxt;

  assign nxt      = cur_addr + STRIDE;
  assign adb_next = (nxt[ADB_LSB-1:0] == '0);
  assign last     = (rem == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rem      <= '0;
      moved    <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      rem      <= ld_beats;
      moved    <= '0;
    end else if (step) begin
      cur_addr <= nxt;
      rem      <= rem - CNT_W'(1);
      moved    <= moved + CNT_W'(1);
    end else if (bump) begin
      moved    <= moved + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mt_sticky.sv
module mt_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag[i] <= 1'b0;
      else if (set[i])
        flag[i] <= 1'b1;
      else if (clr[i])
        flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mt_term_ctrl.sv
module mt_term_ctrl
  import mt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int BEAT_BYTES = 8,
  parameter int ADB_BYTES  = 128,
  parameter int DS_WINDOW  = 6,
  parameter int RETRY_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_split,
  input  logic              req_special,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  output logic              addr_phase,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CNT_W-1:0]  bus_beats,
  output logic              dphase,
  input  logic              dev_sel,
  input  logic              data_ack,
  input  logic              tgt_disc,
  input  logic              tgt_retry,
  input  logic              tgt_abort,
  input  logic              buf_empty,
  input  logic              lat_expired,
  input  logic              gnt,
  output logic              init_disc,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [1:0]        cpl_status,
  output logic [CNT_W-1:0]  cpl_beats,
  input  logic [1:0]        sts_clr,
  output logic [1:0]        sts_flags
);
  localparam int GAP_W = $clog2(RETRY_GAP + 1);

  mt_state_e  st, st_nxt;
  mt_cpl_e    cpl_q, cpl_nxt;
  logic       write_q, split_q, special_q;
  logic [GAP_W-1:0] gap_cnt;
  logic       trk_load, trk_step, trk_bump, trk_last, trk_adb;
  logic       done_now, idisc_now, gap_start, set_ma, set_ta;
  logic       ds_timeout, dry, stall;

  mt_devsel_window #(.WINDOW(DS_WINDOW)) u_window (
    .clk(clk), .rst_n(rst_n),
    .start(st == ST_ADDR), .waiting(st == ST_WAIT),
    .dev_sel(dev_sel), .timeout(ds_timeout)
  );

  mt_xfer_track #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .BEAT_BYTES(BEAT_BYTES), .ADB_BYTES(ADB_BYTES)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .load(trk_load), .ld_addr(req_addr), .ld_beats(req_beats),
    .step(trk_step), .bump(trk_bump),
    .cur_addr(bus_addr), .rem(bus_beats), .moved(cpl_beats),
    .last(trk_last), .adb_next(trk_adb)
  );

  mt_sticky #(.N(2)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set({set_ta, set_ma}), .clr(sts_clr), .flag(sts_flags)
  );

  assign dry   = split_q && buf_empty;
  assign stall = lat_expired && !gnt;

  always_comb begin
    st_nxt    = st;
    cpl_nxt   = CPL_OK;
    trk_load  = 1'b0;
    trk_step  = 1'b0;
    trk_bump  = 1'b0;
    done_now  = 1'b0;
    idisc_now = 1'b0;
    gap_start = 1'b0;
    set_ma    = 1'b0;
    set_ta    = 1'b0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        trk_load = 1'b1;
        st_nxt   = ST_ADDR;
      end
      ST_ADDR: st_nxt = ST_WAIT;
      ST_WAIT: begin
        if (dev_sel) begin
          st_nxt = ST_DATA;
        end else if (ds_timeout) begin
          st_nxt   = ST_DONE;
          done_now = 1'b1;
          if (special_q) begin
            trk_bump = 1'b1;
          end else begin
            cpl_nxt = CPL_MABORT;
            set_ma  = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tgt_retry) begin
          st_nxt    = ST_GAP;
          gap_start = 1'b1;
        end else if (tgt_abort) begin
          st_nxt   = ST_DONE;
          done_now = 1'b1;
          cpl_nxt  = CPL_TABORT;
          set_ta   = 1'b1;
        end else if (data_ack) begin
          trk_step = 1'b1;
          if (trk_last || special_q) begin
            st_nxt   = ST_DONE;
            done_now = 1'b1;
          end else if (tgt_disc) begin
            st_nxt = ST_ADDR;
          end else if (trk_adb && !write_q && (dry || stall)) begin
            st_nxt    = ST_HOLD;
            idisc_now = 1'b1;
          end
        end
      end
      ST_GAP:  if (gap_cnt == GAP_W'(RETRY_GAP)) st_nxt = ST_ADDR;
      ST_HOLD: if (gnt && !dry) st_nxt = ST_ADDR;
      ST_DONE: if (cpl_ready) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cpl_q     <= CPL_OK;
      write_q   <= 1'b0;
      split_q   <= 1'b0;
      special_q <= 1'b0;
      gap_cnt   <= '0;
      init_disc <= 1'b0;
    end else begin
      st        <= st_nxt;
      init_disc <= idisc_now;
      if (trk_load) begin
        write_q   <= req_write;
        split_q   <= req_split;
        special_q <= req_special;
      end
      if (done_now)
        cpl_q <= cpl_nxt;
      if (gap_start)
        gap_cnt <= GAP_W'(1);
      else if (st == ST_GAP)
        gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign addr_phase = (st == ST_ADDR);
  assign dphase     = (st == ST_DATA);
  assign cpl_valid  = (st == ST_DONE);
  assign cpl_status = cpl_q;
endmodule

// File: rtl/mt_term_ctrl_chk.sv
module mt_term_ctrl_chk #(
  parameter int DS_WINDOW = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       addr_phase,
  input logic       dphase,
  input logic       dev_sel,
  input logic       tgt_retry,
  input logic       init_disc,
  input logic       cpl_valid,
  input logic       cpl_ready,
  input logic [1:0] cpl_status,
  input logic [1:0] sts_clr,
  input logic [1:0] sts_flags
);
  localparam int WW = $clog2(DS_WINDOW + 2);

  logic          wr_q;
  logic          ds_seen;
  logic [WW-1:0] wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      ds_seen <= 1'b0;
      wait_n  <= '0;
    end else begin
      if (req_valid && req_ready) wr_q <= req_write;
      if (addr_phase) begin
        ds_seen <= 1'b0;
        wait_n  <= '0;
      end else begin
        if (dev_sel) ds_seen <= 1'b1;
        if (wait_n != WW'(DS_WINDOW + 1)) wait_n <= wait_n + WW'(1);
      end
    end
  end

  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, addr_phase, dphase, cpl_valid})); // R1

  AST_MABORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpl_valid) && cpl_status == 2'b01) |-> (!ds_seen && wait_n == WW'(DS_WINDOW))); // R2

  AST_MABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpl_valid) && cpl_status == 2'b01) |-> sts_flags[0]); // R2

  AST_WRITE_NO_IDISC: assert property (@(posedge clk) disable iff (!rst_n)
    init_disc |-> !wr_q); // R5

  AST_RETRY_QUIET1: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase && tgt_retry) |=> !addr_phase); // R9

  AST_RETRY_QUIET2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dphase && tgt_retry, 2) |-> !addr_phase); // R9

  AST_TABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpl_valid) && cpl_status == 2'b10) |-> sts_flags[1]); // R10

  AST_MA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_flags[0]) && !$past(sts_clr[0])) |-> sts_flags[0]); // R11

  AST_TA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_flags[1]) && !$past(sts_clr[1])) |-> sts_flags[1]); // R11

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_status))); // R12
endmodule

bind mt_term_ctrl mt_term_ctrl_chk #(.DS_WINDOW(DS_WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .addr_phase(addr_phase), .dphase(dphase),
  .dev_sel(dev_sel), .tgt_retry(tgt_retry), .init_disc(init_disc),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
  .sts_clr(sts_clr), .sts_flags(sts_flags)
);

// File: tb/mt_term_ctrl_test.sv
module mt_term_ctrl_test;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int RETRY_GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_split = 0, req_special = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_beats = '0;
  logic dev_sel = 0, data_ack = 0, tgt_disc = 0, tgt_retry = 0, tgt_abort = 0;
  logic buf_empty = 0, lat_expired = 0, gnt = 1, cpl_ready = 0;
  logic [1:0] sts_clr = '0;
  logic req_ready, addr_phase, dphase, init_disc, cpl_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [CNT_W-1:0]  bus_beats, cpl_beats;
  logic [1:0] cpl_status, sts_flags;

  always #10 clk = ~clk;

  mt_term_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_split(req_split), .req_special(req_special),
    .req_addr(req_addr), .req_beats(req_beats), .addr_phase(addr_phase),
    .bus_addr(bus_addr), .bus_beats(bus_beats), .dphase(dphase),
    .dev_sel(dev_sel), .data_ack(data_ack), .tgt_disc(tgt_disc),
    .tgt_retry(tgt_retry), .tgt_abort(tgt_abort), .buf_empty(buf_empty),
    .lat_expired(lat_expired), .gnt(gnt), .init_disc(init_disc),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
    .cpl_beats(cpl_beats), .sts_clr(sts_clr), .sts_flags(sts_flags)
  );

  int n_cmp = 0, n_bad = 0;
  int o_naddr, o_ninit, o_ten1, o_l1addr, o_l1rem, o_l2addr, o_l2rem;
  int o_gapbad, o_holdbad, o_cplbad, o_status, o_beats, o_flags;

  task automatic chk(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic pulse_clr(input logic [1:0] bits);
    sts_clr = bits;
    @(negedge clk);
    sts_clr = '0;
  endtask

  // Bench acts as the target: samples outputs, then drives the next response.
  task automatic run_case(input bit wr, input bit sp, input bit spl, input int a,
                          input int nb, input int d, input int nretry,
                          input int abort_at, input int disc_at, input bit dry,
                          input bit latx, input bit gnt0, input int cpl_hold);
    int j, b, rl, hold, retry_cyc, cyc;
    bit done;
    j = 1000; b = 0; rl = nretry; hold = 0; retry_cyc = -1; cyc = 0; done = 0;
    o_naddr = 0; o_ninit = 0; o_ten1 = -1; o_l1addr = -1; o_l1rem = -1;
    o_l2addr = -1; o_l2rem = -1; o_gapbad = 0; o_holdbad = 0; o_cplbad = 0;
    o_status = -1; o_beats = -1; o_flags = -1;
    buf_empty = dry; lat_expired = latx; gnt = gnt0;
    req_write = wr; req_special = sp; req_split = spl;
    req_addr = ADDR_W'(a); req_beats = CNT_W'(nb); req_valid = 1'b1;
    for (int it = 0; it < 600 && !done; it++) begin
      @(negedge clk);
      cyc++;
      req_valid = 0; dev_sel = 0; data_ack = 0; tgt_disc = 0; tgt_retry = 0; tgt_abort = 0;
      if (cpl_valid) begin
        done = 1;
        o_status = int'(cpl_status); o_beats = int'(cpl_beats); o_flags = int'(sts_flags);
        for (int k = 0; k < cpl_hold; k++) begin
          @(negedge clk);
          if (!cpl_valid || int'(cpl_status) != o_status || int'(cpl_beats) != o_beats || req_ready)
            o_cplbad++;
        end
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        if (!req_ready) o_cplbad++;
      end else begin
        if (addr_phase) begin
          o_naddr++;
          j = 0;
          if (o_naddr == 1) begin o_l1addr = int'(bus_addr); o_l1rem = int'(bus_beats); end
          else if (o_naddr == 2) begin o_l2addr = int'(bus_addr); o_l2rem = int'(bus_beats); end
          if (retry_cyc >= 0) begin
            if (cyc - retry_cyc != RETRY_GAP + 1) o_gapbad++;
            retry_cyc = -1;
          end
          if (hold > 0) o_holdbad++;
        end else begin
          j++;
        end
        if (init_disc) begin
          o_ninit++;
          o_ten1 = b;
          hold = 3;
        end else if (hold > 0) begin
          hold--;
          if (hold == 0) begin buf_empty = 0; gnt = 1; end
        end
        dev_sel = (j == d);
        if (dphase) begin
          if (rl > 0) begin
            tgt_retry = 1; rl--; retry_cyc = cyc;
          end else if (b == abort_at) begin
            tgt_abort = 1;
          end else begin
            data_ack = 1; tgt_disc = (b == disc_at); b++;
          end
        end
      end
    end
    if (!done) chk("R12 completion never arrived", 0, 1);
  endtask

  initial begin
    int n1, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 req_ready after reset", int'(req_ready), 1);
    chk("R13 idle outputs after reset", int'({addr_phase, dphase, cpl_valid, init_disc}), 0);
    chk("R13 flags after reset", int'(sts_flags), 0);

    // Device-select window sweep over read, write and special cycle.
    for (int kind = 0; kind < 3; kind++) begin
      for (int d = 1; d <= 8; d++) begin
        bit sp;
        bit ok;
        sp = (kind == 2);
        ok = (d <= 6);
        pulse_clr(2'b11);
        run_case(kind == 1, sp, 0, 16'h0040, 2, d, 0, -1, -1, 0, 0, 1, 0);
        chk("R1 launch address", o_l1addr, 16'h0040);
        chk("R1 launch beats", o_l1rem, 2);
        if (ok) begin
          chk(sp ? "R3 special with devsel status" : "R4 normal status", o_status, 0);
          chk(sp ? "R3 special with devsel beats" : "R4 normal beats", o_beats, sp ? 1 : 2);
        end else begin
          chk(sp ? "R3 special timeout status" : "R2 master abort status", o_status, sp ? 0 : 1);
          chk(sp ? "R3 special timeout beats" : "R2 master abort beats", o_beats, sp ? 1 : 0);
        end
        chk(sp ? "R3 master abort flag" : "R2 master abort flag", o_flags & 1, (!ok && !sp) ? 1 : 0);
      end
    end

    // Retry spacing and repetition.
    for (int wr = 0; wr < 2; wr++) begin
      for (int nr = 0; nr < 4; nr++) begin
        run_case(wr[0], 0, 0, 16'h0200, 3, 2, nr, -1, -1, 0, 0, 1, 0);
        chk("R9 address phases with retries", o_naddr, nr + 1);
        chk("R9 retry spacing violations", o_gapbad, 0);
        chk("R9 final status", o_status, 0);
        chk("R4 beats after retries", o_beats, 3);
      end
    end

    // Target disconnect at each beat position.
    for (int da = 0; da < 4; da++) begin
      run_case(0, 0, 0, 16'h0300, 4, 1, 0, -1, da, 0, 0, 1, 0);
      chk("R8 address phases", o_naddr, (da < 3) ? 2 : 1);
      if (da < 3) begin
        chk("R8 relaunch address", o_l2addr, 16'h0300 + 8 * (da + 1));
        chk("R8 relaunch beats", o_l2rem, 4 - da - 1);
      end
      chk("R8 total beats", o_beats, 4);
    end

    // Allowable-disconnect-boundary sweep over start offsets.
    for (int s = 72; s <= 128; s += 8) begin
      int off;
      off = s % 128;
      base = 16'h0100 + off;
      n1 = (128 - off) / 8;
      // split read, buffer dry
      run_case(0, 0, 1, base, 6, 1, 0, -1, -1, 1, 0, 1, 0);
      chk("R6 initiator disconnects", o_ninit, (n1 < 6) ? 1 : 0);
      chk("R6 address phases", o_naddr, (n1 < 6) ? 2 : 1);
      if (n1 < 6) begin
        chk("R6 beats before disconnect", o_ten1, n1);
        chk("R6 relaunch address", o_l2addr, base + 8 * n1);
        chk("R6 relaunch beats", o_l2rem, 6 - n1);
      end
      chk("R6 early relaunch while dry", o_holdbad, 0);
      chk("R6 total beats", o_beats, 6);
      // write with every disconnect trigger present
      run_case(1, 0, 1, base, 6, 1, 0, -1, -1, 1, 1, 0, 0);
      chk("R5 write initiator disconnects", o_ninit, 0);
      chk("R5 write beats", o_beats, 6);
      // read, latency expired without grant
      run_case(0, 0, 0, base, 6, 1, 0, -1, -1, 0, 1, 0, 0);
      chk("R7 latency disconnects", o_ninit, (n1 < 6) ? 1 : 0);
      if (n1 < 6) chk("R7 relaunch address", o_l2addr, base + 8 * n1);
      chk("R7 early relaunch without grant", o_holdbad, 0);
      chk("R7 total beats", o_beats, 6);
      // read, latency expired but grant held
      run_case(0, 0, 0, base, 6, 1, 0, -1, -1, 0, 1, 1, 0);
      chk("R7 disconnects with grant held", o_ninit, 0);
    end

    // Target abort on each data phase.
    for (int ab = 0; ab < 4; ab++) begin
      pulse_clr(2'b11);
      run_case(0, 0, 0, 16'h0400, 4, 3, 0, ab, -1, 0, 0, 1, 0);
      chk("R10 target abort status", o_status, 2);
      chk("R10 beats before abort", o_beats, ab);
      chk("R10 flags", o_flags, 2);
    end

    // Sticky flag behaviour (target abort flag is set here).
    pulse_clr(2'b01);
    chk("R11 clear of other bit leaves flag", int'(sts_flags), 2);
    run_case(0, 0, 0, 16'h0500, 2, 1, 0, -1, -1, 0, 0, 1, 0);
    chk("R11 flag survives normal transaction", o_flags, 2);
    pulse_clr(2'b10);
    chk("R11 flag cleared by own bit", int'(sts_flags), 0);

    // Completion back-pressure.
    run_case(0, 0, 0, 16'h0600, 3, 4, 0, -1, -1, 0, 0, 1, 4);
    chk("R12 completion held under back-pressure", o_cplbad, 0);
    chk("R12 completion beats", o_beats, 3);

    finish_run();
  end
endmodule